// File: doc/BRIEF.md
# Multicycle 16-bit Register Processor Core

This block is a small stored-program processor. It takes each instruction through a fixed series of phases: fetch, decode, address evaluation, operand fetch, execute and result store. It skips the phases an instruction does not need, and a phase may last more than one clock. The core reaches memory only through an internal address register and an internal data register. It drives a single-port synchronous memory with separate read and write strobes. Read data comes back on the cycle after the read strobe, and the memory holds it until the next read.

The core has eight 16-bit general registers, a program counter and an instruction register. The instructions are register add, AND and NOT, a load and a store at a base register plus a signed offset, a jump to a register plus an offset, and a branch taken when a register is zero. A run input works as a synchronous enable for the whole core. While it is low, nothing advances and no memory strobe is driven.

Top module: `mc16_core`

## Requirements
- R1: While reset is asserted, both strobes are low and the address output is 0x0000. After reset all registers read as zero, and the first read strobe addresses 0x0000.
- R2: Each instruction begins with one read strobe at the PC. The word read becomes the instruction, and the PC then advances by one.
- R3: Opcode 0001 (add) writes reg[bits 11:9] = reg[bits 8:6] + reg[bits 2:0], modulo 2^16.
- R4: Opcode 0101 (and) writes reg[bits 11:9] = reg[bits 8:6] & reg[bits 2:0].
- R5: Opcode 1001 (not) writes reg[bits 11:9] = ~reg[bits 8:6]. Bits 5:0 are ignored.
- R6: Opcode 0110 (load) reads address reg[bits 8:6] + sign-extended bits 5:0 and writes that word into reg[bits 11:9].
- R7: Opcode 0111 (store) drives one write strobe at reg[bits 8:6] + sign-extended bits 5:0, with data reg[bits 11:9]. The read and write strobes are never high together.
- R8: Opcode 1100 (jump) sets the PC to reg[bits 8:6] + sign-extended bits 5:0.
- R9: Opcode 0000 (branch) sets the PC to the incremented PC + sign-extended bits 5:0 when reg[bits 8:6] is zero. Otherwise it keeps the incremented PC.
- R10: Any other opcode changes no register and goes straight on to the next fetch.
- R11: While run_i is low, no strobe is driven and neither the PC nor the phase changes. When run_i returns high, execution resumes where it stopped.
- R12: Counting the first fetch cycle as cycle 0, the fetch read strobe is at cycle 1. The load read strobe is at cycle 6 and the store write strobe is at cycle 8. Cycles per instruction are: ALU 8, load 9, store 9, jump 7, branch 8, other opcodes 5. Each low cycle of run_i adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Synchronous run enable |
| mem_addr_o | output | 16 | Memory address (from the address register) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data (from the data register) |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after a read strobe |

## Verification
A wrong phase or a wrong register value can only reach the ports as a memory strobe that comes early or late, or at the wrong address, or with wrong data. The bench stamps every expected strobe with its exact cycle. A phase that is skipped or repeated therefore shows up at the very next strobe. A wrong PC appears at the next fetch address. A wrong register value stays hidden until a store or a base-addressed access uses that register, so every computed value is stored soon after it is produced.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int unsigned W      = 16;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned OFF_W  = 6;

  localparam logic [OPC_W-1:0] OPC_BRZ  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND  = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_LDR  = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_STR  = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_NOT  = 4'b1001;
  localparam logic [OPC_W-1:0] OPC_JMPR = 4'b1100;

  typedef enum logic [3:0] {
    S_FMAR, S_FRD, S_FMDR, S_FIR,
    S_DEC,
    S_EA,
    S_OPREG, S_OPRD, S_OPMDR,
    S_EX,
    S_STREG, S_STMAR, S_STWR
  } phase_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASS} alu_op_e;

  typedef struct packed {
    logic              is_alu;
    logic              is_ldr;
    logic              is_str;
    logic              is_jmp;
    logic              is_brz;
    alu_op_e           alu_op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [W-1:0]      imm;
  } dec_t;
endpackage

// File: rtl/mc16_decode.sv
module mc16_decode
  import mc16_pkg::*;
(
  input  logic [W-1:0] ir_i,
  output dec_t         dec_o
);
  localparam int unsigned RD_HI  = W - OPC_W - 1;
  localparam int unsigned RS1_HI = RD_HI - REG_AW;

  always_comb begin
    dec_o        = '0;
    dec_o.rd     = ir_i[RD_HI -: REG_AW];
    dec_o.rs1    = ir_i[RS1_HI -: REG_AW];
    dec_o.rs2    = ir_i[REG_AW-1:0];
    dec_o.imm    = {{(W-OFF_W){ir_i[OFF_W-1]}}, ir_i[OFF_W-1:0]};
    dec_o.alu_op = ALU_PASS;
    case (ir_i[W-1 -: OPC_W])
      OPC_ADD:  begin dec_o.is_alu = 1'b1; dec_o.alu_op = ALU_ADD; end
      OPC_AND:  begin dec_o.is_alu = 1'b1; dec_o.alu_op = ALU_AND; end
      OPC_NOT:  begin dec_o.is_alu = 1'b1; dec_o.alu_op = ALU_NOT; end
      OPC_LDR:  dec_o.is_ldr = 1'b1;
      OPC_STR:  dec_o.is_str = 1'b1;
      OPC_JMPR: dec_o.is_jmp = 1'b1;
      OPC_BRZ:  dec_o.is_brz = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_NOT: y_o = ~a_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(DEPTH)-1:0] raddr_a_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_b_i,
  output logic [WIDTH-1:0]         rdata_a_o,
  output logic [WIDTH-1:0]         rdata_b_o,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [WIDTH-1:0]         wdata_i
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] rf [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic [WIDTH-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              r_q <= '0;
      else if (we_i && waddr_i == AW'(g))       r_q <= wdata_i;
    end
    assign rf[g] = r_q;
  end

  assign rdata_a_o = rf[raddr_a_i];
  assign rdata_b_o = rf[raddr_b_i];

  AST_RF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rf[$past(waddr_i)] == $past(wdata_i)); // R3
endmodule

// File: rtl/mc16_seq.sv
module mc16_seq
  import mc16_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  dec_t   dec_i,
  output phase_e state_o
);
  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_FMAR:  state_d = S_FRD;
      S_FRD:   state_d = S_FMDR;
      S_FMDR:  state_d = S_FIR;
      S_FIR:   state_d = S_DEC;
      S_DEC: begin
        if (dec_i.is_alu)                                           state_d = S_OPREG;
        else if (dec_i.is_ldr || dec_i.is_str || dec_i.is_jmp || dec_i.is_brz) state_d = S_EA;
        else                                                        state_d = S_FMAR;
      end
      S_EA: begin
        if (dec_i.is_ldr)      state_d = S_OPRD;
        else if (dec_i.is_jmp) state_d = S_EX;
        else                   state_d = S_OPREG;
      end
      S_OPREG: state_d = dec_i.is_str ? S_STMAR : S_EX;
      S_OPRD:  state_d = S_OPMDR;
      S_OPMDR: state_d = S_STREG;
      S_EX:    state_d = dec_i.is_alu ? S_STREG : S_FMAR;
      S_STREG: state_d = S_FMAR;
      S_STMAR: state_d = S_STWR;
      S_STWR:  state_d = S_FMAR;
      default: state_d = S_FMAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= S_FMAR;
    else if (run_i) state_q <= state_d;
  end

  assign state_o = state_q;

  AST_FETCH_TO_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state_q == S_FIR) |=> state_q == S_DEC); // R12
  AST_HALT_HOLDS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> state_q == $past(state_q)); // R11
  AST_UNUSED_OPC_REFETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state_q == S_DEC && !dec_i.is_alu && !dec_i.is_ldr && !dec_i.is_str
     && !dec_i.is_jmp && !dec_i.is_brz) |=> state_q == S_FMAR); // R10
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  output logic [15:0] mem_addr_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [15:0] mem_wdata_o,
  input  logic [15:0] mem_rdata_i
);
  localparam int unsigned NREG = 1 << REG_AW;

  phase_e        state;
  dec_t          dec;
  logic [W-1:0]  pc_q, ir_q, mar_q, mdr_q, opa_q, opb_q, res_q, ea_q;
  logic [W-1:0]  rd_a, rd_b, alu_y, ea_sum, rf_wdata;
  logic          rf_we;

  mc16_decode u_dec (.ir_i(ir_q), .dec_o(dec));

  mc16_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .dec_i(dec), .state_o(state)
  );

  mc16_regfile #(.WIDTH(W), .DEPTH(NREG)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .raddr_a_i(dec.rs1),
    .raddr_b_i(dec.is_str ? dec.rd : dec.rs2),
    .rdata_a_o(rd_a), .rdata_b_o(rd_b),
    .we_i(rf_we), .waddr_i(dec.rd), .wdata_i(rf_wdata)
  );

  mc16_alu #(.WIDTH(W)) u_alu (.op_i(dec.alu_op), .a_i(opa_q), .b_i(opb_q), .y_o(alu_y));

  // branch targets are relative to the already incremented PC
  assign ea_sum   = (dec.is_brz ? pc_q : rd_a) + dec.imm;
  assign rf_we    = run_i && state == S_STREG;
  assign rf_wdata = dec.is_ldr ? mdr_q : res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
      ea_q  <= '0;
    end else if (run_i) begin
      case (state)
        S_FMAR:  mar_q <= pc_q;
        S_FMDR:  mdr_q <= mem_rdata_i;
        S_FIR: begin
          ir_q <= mdr_q;
          pc_q <= pc_q + W'(1);
        end
        S_EA: begin
          ea_q <= ea_sum;
          if (dec.is_ldr) mar_q <= ea_sum;
        end
        S_OPREG: begin
          opa_q <= rd_a;
          opb_q <= rd_b;
          if (dec.is_str) mdr_q <= rd_b;
        end
        S_OPMDR: mdr_q <= mem_rdata_i;
        S_EX: begin
          res_q <= alu_y;
          if (dec.is_jmp)                   pc_q <= ea_q;
          if (dec.is_brz && opa_q == '0)    pc_q <= ea_q;
        end
        S_STMAR: mar_q <= ea_q;
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign mem_rd_o    = run_i && (state == S_FRD || state == S_OPRD);
  assign mem_wr_o    = run_i && state == S_STWR;

  AST_RW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R7
  AST_HALT_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pc_q == $past(pc_q)); // R11
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state == S_FIR) |=> pc_q == $past(pc_q) + W'(1)); // R2
  AST_IR_FROM_MDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state == S_FIR) |=> ir_q == $past(mdr_q)); // R2
  AST_BR_FALLTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state == S_EX && dec.is_brz && opa_q != '0) |=> pc_q == $past(pc_q)); // R9
  AST_JMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state == S_EX && dec.is_jmp) |=> pc_q == $past(ea_q)); // R8
endmodule

// File: tb/mc16_core_test.sv
`timescale 1ns/1ps
module mc16_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b1;
  logic [15:0] mem_addr_o, mem_wdata_o;
  logic        mem_rd_o, mem_wr_o;
  logic [15:0] mem_rdata_i = '0;

  mc16_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  always #2 clk_i = ~clk_i;

  logic [15:0] mem [256];
  always @(posedge clk_i) begin
    if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
  end

  int cyc = 0;
  always @(posedge clk_i) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [15:0] data;
    int          cyc;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  bit drv_done = 0, done = 0, timed_out = 0;

  // instruction-level model built from the requirements
  logic [15:0] rm [8];
  logic [15:0] pc_m = 16'h0000;
  int cyc_m = 0;
  int h_off = -1, h_len = 0;
  int hs [4];
  int hl [4];
  int nh = 0;

  function automatic logic [15:0] enc(logic [3:0] op, logic [2:0] a, logic [2:0] b, logic [5:0] lo);
    return {op, a, b, lo};
  endfunction

  function automatic int at(int off);
    return cyc_m + off + ((h_off >= 0 && off >= h_off) ? h_len : 0);
  endfunction

  task automatic push(bit wr, logic [15:0] addr, logic [15:0] data, int c, string req);
    exp_t e;
    e.wr = wr; e.addr = addr; e.data = data; e.cyc = c; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic halt_next(int off, int len);
    h_off = off; h_len = len;
    hs[nh] = cyc_m + off; hl[nh] = len; nh++;
  endtask

  task automatic fetch(logic [15:0] word);
    mem[pc_m[7:0]] = word;
    push(1'b0, pc_m, 16'h0, at(1), "R2");
    pc_m = pc_m + 16'd1;
  endtask

  task automatic fin(int dur);
    cyc_m += dur + ((h_off >= 0) ? h_len : 0);
    h_off = -1; h_len = 0;
  endtask

  task automatic i_ldr(logic [2:0] dr, logic [2:0] base, int off);
    logic [15:0] a;
    fetch(enc(4'b0110, dr, base, off[5:0]));
    a = rm[base] + 16'(off);
    push(1'b0, a, 16'h0, at(6), "R6");
    rm[dr] = mem[a[7:0]];
    fin(9);
  endtask

  task automatic i_str(logic [2:0] sr, logic [2:0] base, int off, string req);
    logic [15:0] a;
    fetch(enc(4'b0111, sr, base, off[5:0]));
    a = rm[base] + 16'(off);
    push(1'b1, a, rm[sr], at(8), req);
    fin(9);
  endtask

  task automatic i_alu(logic [3:0] op, logic [2:0] dr, logic [2:0] s1, logic [2:0] s2);
    if (op == 4'b1001) fetch(enc(op, dr, s1, 6'h3F));
    else               fetch(enc(op, dr, s1, {3'b000, s2}));
    case (op)
      4'b0001: rm[dr] = rm[s1] + rm[s2];
      4'b0101: rm[dr] = rm[s1] & rm[s2];
      default: rm[dr] = ~rm[s1];
    endcase
    fin(8);
  endtask

  task automatic i_jmp(logic [2:0] base, int off);
    fetch(enc(4'b1100, 3'd0, base, off[5:0]));
    pc_m = rm[base] + 16'(off);
    fin(7);
  endtask

  task automatic i_brz(logic [2:0] base, int off);
    fetch(enc(4'b0000, 3'd0, base, off[5:0]));
    if (rm[base] == 16'h0) pc_m = pc_m + 16'(off);
    fin(8);
  endtask

  task automatic i_nop(logic [3:0] op);
    fetch(enc(op, 3'd5, 3'd1, 6'h15));
    fin(5);
  endtask

  task automatic check(bit ok, string req, string what, logic [15:0] act, logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // run enable driver: low inside each scheduled halt window
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      run_i = 1'b1;
      for (int i = 0; i < nh; i++)
        if (rst_ni && cyc >= hs[i] && cyc < hs[i] + hl[i]) run_i = 1'b0;
    end
  end

  // monitor: compares every strobe against the scoreboard queue
  always @(negedge clk_i) begin
    if (rst_ni && drv_done && !done) begin
      if (!run_i) begin
        n_chk++;
        if (mem_rd_o || mem_wr_o) begin
          n_fail++;
          $display("FAIL R11 strobe while halted: rd=%0b wr=%0b expected 0/0 at cycle %0d",
                   mem_rd_o, mem_wr_o, cyc);
        end
      end
      if (mem_rd_o || mem_wr_o) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected strobe: rd=%0b wr=%0b addr=%h expected none",
                   mem_rd_o, mem_wr_o, mem_addr_o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          // R12: cycle stamp is part of every comparison
          if ((mem_rd_o && mem_wr_o) || (mem_wr_o != e.wr) || (mem_addr_o != e.addr) ||
              (e.wr && mem_wdata_o != e.data) || (cyc != e.cyc)) begin
            n_fail++;
            $display("FAIL %s (R12 timing): actual wr=%0b addr=%h data=%h cyc=%0d expected wr=%0b addr=%h data=%h cyc=%0d",
                     e.req, mem_wr_o, mem_addr_o, mem_wdata_o, cyc, e.wr, e.addr, e.data, e.cyc);
          end
        end
      end
      if (exp_q.size() == 0) done = 1;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    timed_out = 1;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 8; i++)   rm[i] = 16'h0000; // R1: registers start at zero
    mem[8'hFF] = 16'h1234;
    mem[8'hFE] = 16'h00F0;
    mem[8'hFA] = 16'hFFFF;
    mem[8'hF8] = 16'h0028;

    i_ldr(3'd1, 3'd0, -1);            // R6 negative offset from R0
    i_ldr(3'd2, 3'd0, -2);
    i_alu(4'b0001, 3'd3, 3'd1, 3'd2);
    i_str(3'd3, 3'd0, -3, "R3");      // 1234+00F0
    i_alu(4'b0101, 3'd4, 3'd1, 3'd2);
    halt_next(8, 2);                  // R11: halt on the write strobe cycle
    i_str(3'd4, 3'd0, -4, "R4");
    i_alu(4'b1001, 3'd5, 3'd1, 3'd0);
    i_str(3'd5, 3'd0, -5, "R5");
    i_ldr(3'd6, 3'd0, -6);
    i_alu(4'b0001, 3'd7, 3'd6, 3'd6); // R3 wrap
    i_str(3'd7, 3'd0, -7, "R7");
    i_brz(3'd0, 2);                   // R9 taken: skips two words
    mem[12] = enc(4'b0111, 3'd1, 3'd0, 6'h36);
    mem[13] = enc(4'b0111, 3'd1, 3'd0, 6'h36);
    halt_next(1, 3);                  // R11: halt on the fetch strobe cycle
    i_brz(3'd1, 5);                   // R9 not taken
    i_nop(4'b1111);                   // R10
    i_nop(4'b0010);                   // R10
    i_ldr(3'd2, 3'd0, -8);
    i_jmp(3'd2, 3);                   // R8 forward to 43
    i_str(3'd2, 3'd0, -9, "R8");
    i_jmp(3'd2, -20);                 // R8 negative offset to 20
    i_str(3'd7, 3'd2, -1, "R6");      // store based on loaded register
    i_str(3'd1, 3'd4, 0, "R10");      // R4/R5 untouched by the no-ops

    #5;
    check(mem_rd_o == 1'b0, "R1", "read strobe in reset", {15'd0, mem_rd_o}, 16'h0);
    check(mem_wr_o == 1'b0, "R1", "write strobe in reset", {15'd0, mem_wr_o}, 16'h0);
    check(mem_addr_o == 16'h0, "R1", "address in reset", mem_addr_o, 16'h0);
    drv_done = 1;
    @(negedge clk_i);
    rst_ni = 1'b1;

    wait (done || timed_out);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: %0d expected strobes outstanding, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule